// File: doc/BRIEF.md
# Selective-Encoding Scan Slice Decoder

This block sits between a narrow tester port and a bank of parallel scan chains. Each tester cycle it takes one small codeword and rebuilds full-width scan slices from the stream. A slice opens with a header word. The header picks the fill value that every chain position takes, and it may name one position to receive the opposite value. Continuation words then name further positions, one per cycle, that also take the opposite value. Only the minority care bits of a slice are ever sent. The majority care bits and all don't-care positions come from the fill value. A slice with no minority bits costs a single tester cycle.

The decoder holds no knowledge of the circuit under test or of the pattern set. Its only parameter is the chain count N. The codeword is ceil(log2(N+1)) + 2 bits wide. A finished slice goes to the chains when the next header arrives, so there is a fixed latency of one slice. A flush input releases the last slice of a pattern. The input stream is continuous-flow with no back-pressure. The decoder accepts one word on every clock and has no ready signal, and the tester inserts idle words where it has nothing to send. On the output side, scan_shift_en is the valid strobe for scan_out. There is no ready input, because the chains always take a released slice.

Top module: `sesd_decoder`

## Requirements
- R1: The codeword is K+2 bits wide, with K = ceil(log2(N+1)). Bits [K+1:K] are the control field and bits [K-1:0] are a position index.
- R2: A control value of 2'b1d is a header with fill value d. It opens a new slice with every position equal to d. If its index is below N, that position takes the value ~d. An index equal to N names no position.
- R3: A control value of 2'b00 is a continuation. It sets the named position (index below N) of the open slice to ~d. Naming a position again has no further effect. A continuation with no slice open changes nothing.
- R4: A control value of 2'b01 is idle. It leaves the open slice and the outputs unchanged.
- R5: A header that arrives while a slice is open releases that slice. On the next cycle, scan_out shows the released slice and scan_shift_en is high.
- R6: On every cycle that is not a release, scan_shift_en is low and scan_out holds its value. This includes every cycle after a continuation or an idle word.
- R7: A high flush releases the open slice with the same timing as R5 and leaves no slice open. The codeword presented in a flush cycle is ignored. A flush with no slice open produces no shift.
- R8: An index greater than N sets idx_err, which stays high until reset. A header with such an index still opens an all-fill slice. A continuation with such an index changes nothing.
- R9: A synchronous active-high reset clears scan_out, scan_shift_en and idx_err, and leaves no slice open.
- R10: A stream produced by the majority rule reproduces every specified bit of every slice on scan_out. Under that rule the fill value is 1 only when the slice's specified 1s outnumber its specified 0s, and only the minority positions are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rst | input | 1 | Synchronous active-high reset |
| cw_in | input | K+2 | Codeword: control in the top two bits, index below them |
| flush | input | 1 | Release the open slice and ignore this cycle's codeword |
| scan_out | output | N | One bit per scan chain |
| scan_shift_en | output | 1 | One-cycle strobe: the chains load scan_out |
| idx_err | output | 1 | Sticky flag for an out-of-range index |

## Verification
The bench runs with eight chains and first walks every one of the 256 fully specified slices through the majority encoder. This covers every minority count from zero to four and both fill values, and it separates a wrong fill choice from a wrong index decode. Random slices with don't-cares follow. They show whether unspecified positions take the fill value, including ties between 1s and 0s. Directed sequences cover the remaining corner cases: duplicate continuations, idle words in the middle of a slice, continuations with no slice open, the no-target index N, out-of-range indices, and a flush that coincides with a header. Each of these tells ignoring a word apart from acting on it.

// File: rtl/sesd_pkg.sv
package sesd_pkg;
  typedef enum logic [1:0] {
    CT_CONT = 2'b00,
    CT_IDLE = 2'b01,
    CT_HDR0 = 2'b10,
    CT_HDR1 = 2'b11
  } ctrl_e;

  function automatic int index_width(input int chains);
    return $clog2(chains + 1);
  endfunction
endpackage

// File: rtl/sesd_cw_parse.sv
module sesd_cw_parse
  import sesd_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 4
) (
  input  logic [K+1:0] cw,
  input  logic         flush,
  output logic         is_hdr,
  output logic         is_cont,
  output logic         fill_val,
  output logic         bad_idx,
  output logic [N-1:0] hit
);
  ctrl_e        ctrl;
  logic [K-1:0] idx;
  logic         acts;

  always_comb begin
    ctrl     = ctrl_e'(cw[K+1:K]);
    idx      = cw[K-1:0];
    is_hdr   = cw[K+1] && !flush;
    is_cont  = (ctrl == CT_CONT) && !flush;
    fill_val = cw[K];
    acts     = is_hdr || is_cont;
    bad_idx  = acts && (idx > K'(N));
  end

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = acts && (idx == K'(i));
  end
endmodule

// File: rtl/sesd_slice_buf.sv
module sesd_slice_buf #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         is_hdr,
  input  logic         is_cont,
  input  logic         fill_val,
  input  logic         flush,
  input  logic [N-1:0] hit,
  output logic [N-1:0] slice_q,
  output logic         pending_q
);
  logic def_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slice_q   <= '0;
      def_q     <= 1'b0;
      pending_q <= 1'b0;
    end else if (is_hdr) begin
      slice_q   <= {N{fill_val}} ^ hit;
      def_q     <= fill_val;
      pending_q <= 1'b1;
    end else if (flush) begin
      pending_q <= 1'b0;
    end else if (is_cont && pending_q) begin
      for (int i = 0; i < N; i++) begin
        if (hit[i]) slice_q[i] <= ~def_q;
      end
    end
  end

  p_hdr_opens_r2: assert property (@(posedge clk) disable iff (rst)
    is_hdr |=> pending_q);

  p_flush_closes_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pending_q);

  p_cont_marks_r3: assert property (@(posedge clk) disable iff (rst)
    (is_cont && pending_q) |=>
      ((slice_q & $past(hit)) == ($past(def_q) ? '0 : $past(hit))));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (!is_hdr && !is_cont && !flush) |=> ($stable(slice_q) && $stable(pending_q)));
endmodule

// File: rtl/sesd_out_stage.sv
module sesd_out_stage #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         release_now,
  input  logic [N-1:0] slice_in,
  output logic [N-1:0] scan_out,
  output logic         scan_shift_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scan_out      <= '0;
      scan_shift_en <= 1'b0;
    end else begin
      scan_shift_en <= release_now;
      if (release_now) scan_out <= slice_in;
    end
  end

  p_hold_when_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !scan_shift_en |-> $stable(scan_out));
endmodule

// File: rtl/sesd_decoder.sv
module sesd_decoder
  import sesd_pkg::*;
#(
  parameter int N = 8,
  localparam int K = index_width(N),
  localparam int C = K + 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [C-1:0] cw_in,
  input  logic         flush,
  output logic [N-1:0] scan_out,
  output logic         scan_shift_en,
  output logic         idx_err
);
  logic         is_hdr, is_cont, fill_val, bad_idx, pending_q;
  logic [N-1:0] hit, slice_q;
  logic         release_now;

  sesd_cw_parse #(.N(N), .K(K)) u_parse (
    .cw(cw_in), .flush(flush), .is_hdr(is_hdr), .is_cont(is_cont),
    .fill_val(fill_val), .bad_idx(bad_idx), .hit(hit)
  );

  sesd_slice_buf #(.N(N)) u_buf (
    .clk(clk), .rst(rst), .is_hdr(is_hdr), .is_cont(is_cont),
    .fill_val(fill_val), .flush(flush), .hit(hit),
    .slice_q(slice_q), .pending_q(pending_q)
  );

  assign release_now = pending_q && (is_hdr || flush);

  sesd_out_stage #(.N(N)) u_out (
    .clk(clk), .rst(rst), .release_now(release_now), .slice_in(slice_q),
    .scan_out(scan_out), .scan_shift_en(scan_shift_en)
  );

  always_ff @(posedge clk) begin
    if (rst) idx_err <= 1'b0;
    else     idx_err <= idx_err || bad_idx;
  end

  p_shift_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    scan_shift_en |-> $past(cw_in[C-1] || flush));

  p_no_shift_on_cont_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!flush && !cw_in[C-1]) |-> !scan_shift_en);

  p_err_sets_r8: assert property (@(posedge clk) disable iff (rst)
    bad_idx |=> idx_err);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(idx_err) |-> idx_err);
endmodule

// File: tb/tb_sesd_decoder.sv
module tb_sesd_decoder;
  localparam int N = 8;
  localparam int K = $clog2(N + 1);
  localparam int C = K + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [C-1:0] cw_in = '0;
  logic         flush = 1'b0;
  logic [N-1:0] scan_out;
  logic         scan_shift_en;
  logic         idx_err;

  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 0;
  bit  have_prev = 0;
  logic [N-1:0] prev_exp = '0;

  always #5 clk = ~clk;

  sesd_decoder #(.N(N)) dut (
    .clk(clk), .rst(rst), .cw_in(cw_in), .flush(flush),
    .scan_out(scan_out), .scan_shift_en(scan_shift_en), .idx_err(idx_err)
  );

  function automatic logic [C-1:0] w_hdr(input logic d, input int idx);
    return {1'b1, d, K'(idx)};
  endfunction
  function automatic logic [C-1:0] w_cont(input int idx);
    return {2'b00, K'(idx)};
  endfunction
  function automatic logic [C-1:0] w_idle();
    return {2'b01, K'(0)};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [C-1:0] w, input logic fl);
    cw_in = w;
    flush = fl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cw_in = w_idle();
    flush = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 scan_out", scan_out, 0);
    chk("R9 shift", scan_shift_en, 0);
    chk("R9 err", idx_err, 0);
    rst = 1'b0;
    have_prev = 0;
  endtask

  // R1 R10: encode with the majority rule, stream and compare the previous slice
  task automatic send_slice(input logic [N-1:0] val, input logic [N-1:0] care);
    int ones, zeros, fi;
    logic d;
    logic [N-1:0] m;
    ones  = $countones(val & care);
    zeros = $countones(~val & care);
    d     = (ones > zeros);
    m     = care & (d ? ~val : val);
    fi    = N;
    for (int i = N - 1; i >= 0; i--) if (m[i]) fi = i;
    step(w_hdr(d, fi), 1'b0);
    if (have_prev) begin
      chk("R5 shift on header", scan_shift_en, 1);
      chk("R10 slice bits", scan_out, prev_exp);
    end else begin
      chk("R6 no shift on first header", scan_shift_en, 0);
    end
    for (int i = fi + 1; i < N; i++) begin
      if (m[i]) begin
        step(w_cont(i), 1'b0);
        chk("R6 no shift on continuation", scan_shift_en, 0);
      end
    end
    prev_exp  = (val & care) | ({N{d}} & ~care);
    have_prev = 1;
  endtask

  task automatic flush_check();
    step(w_idle(), 1'b1);
    chk("R7 flush shift", scan_shift_en, 1);
    chk("R10 last slice", scan_out, prev_exp);
    have_prev = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // R9: nothing pending after reset, a flush gives no shift
    step(w_idle(), 1'b1);
    chk("R9 flush after reset", scan_shift_en, 0);

    // R3: a continuation with no slice open does nothing
    step(w_cont(3), 1'b0);
    chk("R3 cont without slice", scan_shift_en, 0);
    chk("R3 cont without slice out", scan_out, 0);

    // R2: index N names no position
    step(w_hdr(1'b1, N), 1'b0);
    chk("R2 header no shift", scan_shift_en, 0);
    step(w_idle(), 1'b1);
    chk("R2 flush shift", scan_shift_en, 1);
    chk("R2 all fill", scan_out, 8'hFF);

    // R3 R4 R6: target, duplicate, idle in mid-slice
    step(w_hdr(1'b0, 2), 1'b0);
    step(w_cont(5), 1'b0);
    chk("R6 cont quiet", scan_shift_en, 0);
    step(w_cont(5), 1'b0);
    chk("R6 dup quiet", scan_shift_en, 0);
    step(w_idle(), 1'b0);
    chk("R4 idle quiet", scan_shift_en, 0);
    chk("R4 idle out held", scan_out, 8'hFF);
    step(w_idle(), 1'b1);
    chk("R3 marked bits", scan_out, 8'h24);

    // R7: flush and header in the same cycle, the header is ignored
    step(w_hdr(1'b1, 0), 1'b0);
    step(w_hdr(1'b0, 1), 1'b1);
    chk("R7 flush shift", scan_shift_en, 1);
    chk("R7 flushed slice", scan_out, 8'hFE);
    step(w_idle(), 1'b1);
    chk("R7 header in flush ignored", scan_shift_en, 0);

    // R8: out-of-range indices
    step(w_hdr(1'b0, 9), 1'b0);
    chk("R8 err set", idx_err, 1);
    step(w_cont(12), 1'b0);
    step(w_idle(), 1'b0);
    chk("R8 err sticky", idx_err, 1);
    step(w_idle(), 1'b1);
    chk("R8 bad header slice", scan_out, 8'h00);
    do_reset();

    // R10: every fully specified slice
    for (int v = 0; v < (1 << N); v++) send_slice(N'(v), '1);
    flush_check();

    // R10: random slices with don't-cares
    for (int t = 0; t < 300; t++) send_slice(N'($urandom), N'($urandom));
    flush_check();
    chk("R8 no err on legal stream", idx_err, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule